// File: doc/BRIEF.md
# Video Display Output Formatter

This block builds the word driven onto a digital video display bus on every pixel clock. An external timing generator supplies an active-window flag and pixel and line counters. An upstream first-word-fall-through FIFO supplies image samples. The formatter decides whether each position shows image data or a programmable fill value. It pops the FIFO only for image positions that have data. It places 8-bit components in the correct bus lanes and registers the result.

Three formats are supported. The first is a single-lane 4:2:2 interleave with chroma and luma alternating in the order Cb, Y, Cr, Y. The second splits the bus into two lanes, with luma on one and alternating chroma on the other. The third is a raw mode with a selectable width of 8, 10, 16 or 20 bits. In the two component formats, image samples are clamped to programmable luma and chroma ranges. Raw samples pass through untouched. The fill value covers three cases: the border between the active window edge and the image offsets, raw-mode blanking, and FIFO underflow when the underflow-fill control is set.

Configuration goes through a write-only port. Timing generation, sync code insertion and the FIFO itself belong to other blocks.

Top module: `vid_out_fmt`

## Requirements
- R1: Register address 1 holds the clamp limits: chroma-high in bits 31:24, chroma-low in bits 23:16, luma-high in bits 15:8 and luma-low in bits 7:0. After reset these are F0h, 10h, EBh and 10h.
- R2: In the component formats, an image chroma sample above chroma-high is output as chroma-high, and one below chroma-low is output as chroma-low. Otherwise the sample is output unchanged.
- R3: In the component formats, an image luma sample is clamped in the same way to the luma-low and luma-high limits.
- R4: Control register (address 0) bits 1:0 select the format: 0 interleaved, 1 two-lane, 2 or 3 raw. Bits 3:2 select the raw width: 0 = 8, 1 = 10, 2 = 16, 3 = 20 bits. In raw mode the source word is output masked to that width, with no clamping.
- R5: A position is an image position when the active flag is high, the line count is at least the vertical offset and the pixel count is at least the horizontal offset. Active positions that are not image positions output the fill value. `fifo_rd_o` is high exactly for image positions where the FIFO is not empty.
- R6: In the interleaved format, a 2-bit phase clears whenever the active flag is low and advances on each active pixel. Phases 0, 1, 2 and 3 carry Cb, Y, Cr and Y. The byte sits on bits 9:2, and all other bits are 0.
- R7: In the two-lane format, luma sits on bits 9:2 and chroma on bits 19:12. Fill chroma alternates Cb then Cr from the first active pixel. Bits 1:0, 11:10 and 10-lane padding are 0.
- R8: Outside the active window, raw mode outputs the masked fill value and the component formats output all zeros.
- R9: When control bit 4 (underflow fill) is set and the FIFO is empty at an image position, the fill value is output.
- R10: When control bit 4 is clear and the FIFO is empty at an image position, the bus holds its previous value.
- R11: The output is registered: the value for inputs presented in one cycle appears after the next rising clock edge, and the bus is 0 after reset.
- R12: The fill register (address 2) holds fill Y in bits 7:0, Cb in bits 15:8 and Cr in bits 23:16. Raw mode uses its low 20 bits. Address 3 holds the horizontal offset from bit 0 and the vertical offset from bit 16. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| active_i | input | 1 | Active video window flag |
| pix_cnt_i | input | CNT_W | Pixel count within the active line |
| line_cnt_i | input | CNT_W | Line count within the active frame |
| fifo_empty_i | input | 1 | FIFO has no data |
| fifo_data_i | input | DW | FIFO head word |
| fifo_rd_o | output | 1 | FIFO pop strobe |
| dout_o | output | DW | Registered display bus |

## Verification
The assertions check these properties on every cycle:
- the FIFO is never popped while it is empty or outside the active window;
- the component formats keep their padding bits at zero and drive a blank bus outside the window;
- raw output never has bits set above the selected width;
- clamped luma always lies within the limits that were in force;
- the phase counter clears and advances as specified.

Some behaviours can only be shown by the bench's scenarios, because they depend on exact values and sequences. These are the reset clamp limits, the Cb/Y/Cr/Y fill order, the Cb/Cr alternation in the two-lane format, the border and underflow fill values in each format, and the bus holding its value on an underflow without fill.

// File: rtl/vid_fmt_pkg.sv
package vid_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_ILV  = 2'd0,
    FMT_DUAL = 2'd1,
    FMT_RAW  = 2'd2,
    FMT_RAW2 = 2'd3
  } fmt_e;

  typedef struct packed {
    logic       fill_on_empty;
    logic [1:0] raw_wsel;
    fmt_e       fmt;
  } ctrl_t;

  typedef struct packed {
    logic [7:0] c_hi;
    logic [7:0] c_lo;
    logic [7:0] y_hi;
    logic [7:0] y_lo;
  } clip_t;

  localparam clip_t CLIP_RST = '{c_hi: 8'hF0, c_lo: 8'h10, y_hi: 8'hEB, y_lo: 8'h10};

  typedef struct packed {
    logic [7:0] cr;
    logic [7:0] cb;
    logic [7:0] y;
  } fill_t;
endpackage

// File: rtl/vid_fmt_regs.sv
module vid_fmt_regs
  import vid_fmt_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output ctrl_t            ctrl_o,
  output clip_t            clip_o,
  output fill_t            fill_o,
  output logic [CNT_W-1:0] hoff_o,
  output logic [CNT_W-1:0] voff_o
);
  localparam int VOFF_LSB = 16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      clip_o <= CLIP_RST;
      fill_o <= '0;
      hoff_o <= '0;
      voff_o <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        2'd0: ctrl_o <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
        2'd1: clip_o <= clip_t'(wdata_i);
        2'd2: fill_o <= fill_t'(wdata_i[$bits(fill_t)-1:0]);
        default: begin
          hoff_o <= wdata_i[CNT_W-1:0];
          voff_o <= wdata_i[VOFF_LSB +: CNT_W];
        end
      endcase
    end
  end
endmodule

// File: rtl/vid_clamp.sv
module vid_clamp #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic [W-1:0] val_o
);
  always_comb begin
    if (val_i > hi_i)      val_o = hi_i;
    else if (val_i < lo_i) val_o = lo_i;
    else                   val_o = val_i;
  end
endmodule

// File: rtl/vid_fmt_phase.sv
module vid_fmt_phase (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  output logic [1:0] ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_o <= '0;
    else if (!active_i) ph_o <= '0;
    else                ph_o <= ph_o + 2'd1;
  end

  // R6
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> ph_o == 2'd0);

  // R6
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |=> ph_o == $past(ph_o) + 2'd1);
endmodule

// File: rtl/vid_out_fmt.sv
module vid_out_fmt
  import vid_fmt_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DW    = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [31:0]      cfg_wdata_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] pix_cnt_i,
  input  logic [CNT_W-1:0] line_cnt_i,
  input  logic             fifo_empty_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             fifo_rd_o,
  output logic [DW-1:0]    dout_o
);
  localparam int LANE = DW / 2;
  localparam int PAD  = LANE - 8;

  ctrl_t            ctrl;
  clip_t            clip;
  fill_t            fill;
  logic [CNT_W-1:0] hoff, voff;
  logic [1:0]       ph;

  vid_fmt_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .clip_o(clip), .fill_o(fill), .hoff_o(hoff), .voff_o(voff)
  );

  vid_fmt_phase i_phase (.clk_i, .rst_ni, .active_i, .ph_o(ph));

  // component 0 = luma, 1 = chroma
  logic [1:0][7:0] cmp_in, cmp_lo, cmp_hi, cmp_clp;
  assign cmp_in[0] = fifo_data_i[7:0];
  assign cmp_in[1] = (ctrl.fmt == FMT_DUAL) ? fifo_data_i[LANE +: 8] : fifo_data_i[7:0];
  assign cmp_lo    = {clip.c_lo, clip.y_lo};
  assign cmp_hi    = {clip.c_hi, clip.y_hi};

  for (genvar g = 0; g < 2; g++) begin : g_clamp
    vid_clamp #(.W(8)) i_clamp (
      .val_i(cmp_in[g]), .lo_i(cmp_lo[g]), .hi_i(cmp_hi[g]), .val_o(cmp_clp[g])
    );
  end

  logic img, use_fill, hold, raw, is_luma;
  assign raw      = ctrl.fmt[1];
  assign img      = active_i && (line_cnt_i >= voff) && (pix_cnt_i >= hoff);
  assign fifo_rd_o = img && !fifo_empty_i;
  assign use_fill = active_i && (!img || (fifo_empty_i && ctrl.fill_on_empty));
  assign hold     = img && fifo_empty_i && !ctrl.fill_on_empty;
  assign is_luma  = ph[0];

  logic [DW-1:0] raw_msk;
  always_comb begin
    unique case (ctrl.raw_wsel)
      2'd0:    raw_msk = {{(DW-8){1'b0}}, {8{1'b1}}};
      2'd1:    raw_msk = {{(DW-10){1'b0}}, {10{1'b1}}};
      2'd2:    raw_msk = {{(DW-16){1'b0}}, {16{1'b1}}};
      default: raw_msk = '1;
    endcase
  end

  logic [7:0]    ilv_byte, dual_y, dual_c, fill_c_ilv, fill_c_dual;
  logic [DW-1:0] raw_src, nxt;
  assign fill_c_ilv  = ph[1] ? fill.cr : fill.cb;
  assign fill_c_dual = ph[0] ? fill.cr : fill.cb;
  assign ilv_byte    = use_fill ? (is_luma ? fill.y : fill_c_ilv)
                                : (is_luma ? cmp_clp[0] : cmp_clp[1]);
  assign dual_y      = use_fill ? fill.y : cmp_clp[0];
  assign dual_c      = use_fill ? fill_c_dual : cmp_clp[1];
  assign raw_src     = (active_i && !use_fill) ? fifo_data_i
                                               : DW'({fill.cr, fill.cb, fill.y});

  always_comb begin
    if (raw)            nxt = raw_src & raw_msk;
    else if (!active_i) nxt = '0;
    else if (ctrl.fmt == FMT_DUAL)
      nxt = {dual_c, {PAD{1'b0}}, dual_y, {PAD{1'b0}}};
    else
      nxt = {{LANE{1'b0}}, ilv_byte, {PAD{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (!hold) dout_o <= nxt;
  end

  // R5
  rd_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> (!fifo_empty_i && active_i));

  // R6 R7
  lane_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw && !hold) |=> (dout_o[PAD-1:0] == '0 && dout_o[LANE +: PAD] == '0));

  // R8
  blank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!raw && !active_i) |=> dout_o == '0);

  // R4
  raw_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && !hold) |=> (dout_o & ~$past(raw_msk)) == '0);

  // R3
  luma_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.fmt == FMT_ILV && fifo_rd_o && is_luma && !ctrl.fill_on_empty
     && clip.y_lo <= clip.y_hi)
    |=> (dout_o[PAD +: 8] >= $past(clip.y_lo) && dout_o[PAD +: 8] <= $past(clip.y_hi)));
endmodule

// File: tb/test_vid_out_fmt.sv
`timescale 1ns/1ps
module test_vid_out_fmt;
  localparam int CNT_W = 12;
  localparam int DW    = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             active = 1'b0;
  logic [CNT_W-1:0] pix = '0;
  logic [CNT_W-1:0] line = '0;
  logic             empty = 1'b0;
  logic [DW-1:0]    din = '0;
  logic             fifo_rd;
  logic [DW-1:0]    dout;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  vid_out_fmt #(.CNT_W(CNT_W), .DW(DW)) i_vid_out_fmt (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .active_i(active), .pix_cnt_i(pix), .line_cnt_i(line),
    .fifo_empty_i(empty), .fifo_data_i(din),
    .fifo_rd_o(fifo_rd), .dout_o(dout)
  );

  typedef struct packed {
    logic [4:0]       ctrl;
    logic             act;
    logic [CNT_W-1:0] px;
    logic [CNT_W-1:0] ln;
    logic             emp;
    logic [DW-1:0]    dat;
    logic             rd;
    logic [DW-1:0]    exp_out;
    logic [3:0]       req;
  } vec_t;

  // fill = Y 96h, Cb C3h, Cr 5Ah; hoff 4, voff 2; clamp limits at reset values
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{5'h00, 1'b1, 12'd10, 12'd5, 1'b0, 20'h000FF, 1'b1, 20'h003C0, 4'd2},  // R2 Cb high
    '{5'h00, 1'b1, 12'd10, 12'd5, 1'b0, 20'h00005, 1'b1, 20'h00040, 4'd2},  // R2 Cb low
    '{5'h00, 1'b1, 12'd10, 12'd5, 1'b0, 20'h00080, 1'b1, 20'h00200, 4'd2},  // R2 pass
    '{5'h00, 1'b1, 12'd2,  12'd5, 1'b0, 20'h00000, 1'b0, 20'h0030C, 4'd5},  // R5 h border
    '{5'h00, 1'b1, 12'd10, 12'd1, 1'b0, 20'h00000, 1'b0, 20'h0030C, 4'd5},  // R5 v border
    '{5'h00, 1'b0, 12'd10, 12'd5, 1'b0, 20'h000FF, 1'b0, 20'h00000, 4'd8},  // R8 blank zero
    '{5'h01, 1'b1, 12'd10, 12'd5, 1'b0, 20'h000FF, 1'b1, 20'h103AC, 4'd3},  // R3 dual lanes
    '{5'h01, 1'b1, 12'd0,  12'd5, 1'b0, 20'h00000, 1'b0, 20'hC3258, 4'd7},  // R7 dual fill
    '{5'h02, 1'b1, 12'd10, 12'd5, 1'b0, 20'hFFFFF, 1'b1, 20'h000FF, 4'd4},  // R4 raw 8
    '{5'h0E, 1'b1, 12'd10, 12'd5, 1'b0, 20'h12345, 1'b1, 20'h12345, 4'd4},  // R4 raw 20
    '{5'h06, 1'b0, 12'd10, 12'd5, 1'b0, 20'h00000, 1'b0, 20'h00396, 4'd8},  // R8 raw blank 10
    '{5'h0A, 1'b1, 12'd2,  12'd5, 1'b0, 20'h00000, 1'b0, 20'h0C396, 4'd5},  // R5 raw border 16
    '{5'h0E, 1'b0, 12'd0,  12'd0, 1'b0, 20'h00000, 1'b0, 20'hAC396, 4'd8},  // R8 raw blank 20
    '{5'h10, 1'b1, 12'd10, 12'd5, 1'b1, 20'h00000, 1'b0, 20'h0030C, 4'd9},  // R9 ilv
    '{5'h1E, 1'b1, 12'd10, 12'd5, 1'b1, 20'h00000, 1'b0, 20'hAC396, 4'd9},  // R9 raw
    '{5'h11, 1'b1, 12'd10, 12'd5, 1'b1, 20'h00000, 1'b0, 20'hC3258, 4'd9},  // R9 dual
    '{5'h02, 1'b1, 12'd10, 12'd5, 1'b0, 20'h00000, 1'b1, 20'h00000, 4'd4}   // R4 no clamp
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; active = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present one pixel, check pop strobe before the edge and bus after it (R11)
  task automatic px(input logic a, input int p, input int l, input logic e,
                    input logic [DW-1:0] d, input logic exp_rd,
                    input logic [DW-1:0] exp_out, input int req);
    active = a; pix = CNT_W'(p); line = CNT_W'(l); empty = e; din = d;
    #1;
    chk(req, "fifo_rd", 32'(fifo_rd), 32'(exp_rd));
    @(negedge clk);
    chk(req, "dout", 32'(dout), 32'(exp_out));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(11, "reset dout", 32'(dout), 32'h0);
    chk(11, "reset rd", 32'(fifo_rd), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset clamp limits, R6 Cb Y Cr Y phases, offsets reset to 0
    px(1'b1, 0, 0, 1'b0, 20'hFF, 1'b1, 20'h003C0, 1);
    px(1'b1, 1, 0, 1'b0, 20'h00, 1'b1, 20'h00040, 1);
    px(1'b1, 2, 0, 1'b0, 20'hFF, 1'b1, 20'h003C0, 1);
    px(1'b1, 3, 0, 1'b0, 20'h00, 1'b1, 20'h00040, 1);
    px(1'b0, 0, 0, 1'b0, 20'hFF, 1'b0, 20'h00000, 8);
    px(1'b1, 0, 0, 1'b0, 20'h00, 1'b1, 20'h00040, 1);
    px(1'b1, 1, 0, 1'b0, 20'hFF, 1'b1, 20'h003AC, 1);

    // R12 fill and offsets
    wr(2'd2, 32'h005AC396);
    wr(2'd3, 32'h00020004);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, 32'(VECS[i].ctrl));
      px(VECS[i].act, int'(VECS[i].px), int'(VECS[i].ln), VECS[i].emp, VECS[i].dat,
         VECS[i].rd, VECS[i].exp_out, int'(VECS[i].req));
    end

    // R6 fill interleave across a border, then R10 underflow hold
    wr(2'd0, 32'h0);
    px(1'b1, 0, 5, 1'b0, 20'h0,  1'b0, 20'h0030C, 6);
    px(1'b1, 1, 5, 1'b0, 20'h0,  1'b0, 20'h00258, 6);
    px(1'b1, 2, 5, 1'b0, 20'h0,  1'b0, 20'h00168, 6);
    px(1'b1, 3, 5, 1'b0, 20'h0,  1'b0, 20'h00258, 6);
    px(1'b1, 4, 5, 1'b0, 20'h80, 1'b1, 20'h00200, 10);
    px(1'b1, 5, 5, 1'b1, 20'hFF, 1'b0, 20'h00200, 10);

    // R7 dual-lane chroma alternation
    wr(2'd0, 32'h1);
    px(1'b1, 0, 5, 1'b0, 20'h0, 1'b0, 20'hC3258, 7);
    px(1'b1, 1, 5, 1'b0, 20'h0, 1'b0, 20'h5A258, 7);
    px(1'b1, 2, 5, 1'b0, 20'h0, 1'b0, 20'hC3258, 7);

    // R1 R2 R3 programmed limits
    wr(2'd1, 32'hC020B030);
    wr(2'd0, 32'h0);
    px(1'b1, 4, 5, 1'b0, 20'hFF, 1'b1, 20'h00300, 2);
    px(1'b1, 5, 5, 1'b0, 20'h00, 1'b1, 20'h000C0, 3);
    px(1'b1, 6, 5, 1'b0, 20'h00, 1'b1, 20'h00080, 2);
    px(1'b1, 7, 5, 1'b0, 20'hFF, 1'b1, 20'h002C0, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule